// File: doc/BRIEF.md
# Receive Address CAM Filter

This block filters received frames by exact match. It holds two tables. The multicast table stores 48-bit destination addresses. The VLAN table stores 16-bit tags. Each table has the same number of entries (32 by default) and its own per-entry enable mask. A lookup request presents a key and names one table. The key is compared in parallel against every enabled entry of that table. One cycle later the block reports whether any entry matched and the index of the lowest-numbered entry that did.

Software programs both tables through one byte-wide register window. It opens the window and picks a table in the control register. It writes the entry index and stages the key bytes. It then sets the commit bit. That bit reads back as 1 while the update is in progress and clears itself afterwards. Writing zero to control closes the window. While the window is closed, index, data and mask writes are dropped.

Top module: `rx_addr_cam`

## Requirements
- R1: A commit whose entry index (address 1, 8 bits) is 32 or more changes no entry in either table. Indices 0 to 31 are accepted.
- R2: The control register sits at address 0. Bit 0 opens the window, bit 1 selects the VLAN table (0 selects multicast) and bit 2 requests a commit. A commit is accepted only when bit 0 is also set in the same written value.
- R3: A multicast key is staged in bytes at addresses 2 to 7, where address 2+k holds key bits 8k+7 to 8k. The indexed entry takes the staged key only when a commit is accepted. Staging alone changes nothing.
- R4: After an accepted commit, control bit 2 reads 1 for exactly 4 cycles and then reads 0.
- R5: A VLAN tag is staged at address 8 (bits 7:0) and address 9 (bits 15:8). A VLAN lookup compares key bits 15:0 against the VLAN table only. The two tables never affect each other.
- R6: The mask bytes at addresses 10 to 13 write the mask of the table currently selected. Address 10+k holds mask bits 8k+7 to 8k, and these bytes read back. Mask bit n enables entry n, and a disabled entry never matches.
- R7: After reset, control reads 0, both masks are zero and no lookup matches.
- R8: A commit request that arrives while the commit bit still reads 1 is ignored. No entry is written and the busy period is not extended.
- R9: The cycle after `lk_valid` is high, `lk_done` is 1. At that point `lk_hit` reports whether any enabled entry matched and `lk_idx` gives the lowest matching index. When `lk_valid` is low, `lk_done` and `lk_hit` are 0 in the next cycle.
- R10: While the window is closed (control written with bit 0 clear), writes to the index, data and mask registers are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_vlan | input | 1 | Lookup table: 1 VLAN, 0 multicast |
| lk_key | input | 48 | Lookup key (VLAN uses bits 15:0) |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Some enabled entry matched |
| lk_idx | output | 5 | Lowest matching entry index |

## Verification
A lookup and a commit can land on the same clock edge, and both can target the same entry. The bench provokes this by staging a new key for an entry that already matches. It then raises the commit write and a lookup of the old key together. The result of that lookup must still report the old key as a hit at that index. After the busy bit clears, the old key must miss and the new key must hit.

// File: rtl/rx_cam_pkg.sv
package rx_cam_pkg;
  localparam int unsigned RA_W = 4;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_IDX  = 4'd1;
  localparam int unsigned A_MC0 = 2;
  localparam logic [3:0] A_VL0  = 4'd8;
  localparam logic [3:0] A_VL1  = 4'd9;
  localparam int unsigned A_MSK0 = 10;
  localparam int unsigned MC_BYTES = 6;

  // lowest set bit of a vector of up to 64 bits
  function automatic logic [7:0] first_one(input logic [63:0] v);
    logic [7:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = 8'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/cam_regs.sv
module cam_regs
  import rx_cam_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned LAT     = 4,
  localparam int unsigned MB     = ENTRIES / 8,
  localparam int unsigned LW     = (MB > 1) ? $clog2(MB) : 1,
  localparam int unsigned CW     = $clog2(LAT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [ENTRIES-1:0] mc_mask,
  input  logic [ENTRIES-1:0] vl_mask,
  output logic               mc_wr,
  output logic               vl_wr,
  output logic [7:0]         wr_idx,
  output logic [47:0]        mc_stage,
  output logic [15:0]        vl_stage,
  output logic               mc_mask_we,
  output logic               vl_mask_we,
  output logic [LW-1:0]      mask_lane,
  output logic               win_open
);
  logic          en_q, sel_q;
  logic [7:0]    idx_q;
  logic [CW-1:0] cnt;
  logic          ctrl_wr, busy, commit_fire, idx_ok, gated, mask_hit;

  assign ctrl_wr     = reg_wr && (reg_addr == A_CTRL);
  assign busy        = (cnt != '0);
  assign commit_fire = ctrl_wr && reg_wdata[0] && reg_wdata[2] && !busy;
  assign idx_ok      = (32'(idx_q) < ENTRIES);
  assign mc_wr       = commit_fire && !reg_wdata[1] && idx_ok;
  assign vl_wr       = commit_fire &&  reg_wdata[1] && idx_ok;
  assign gated       = reg_wr && en_q;
  assign mask_hit    = (32'(reg_addr) >= A_MSK0) && (32'(reg_addr) < A_MSK0 + MB);
  assign mask_lane   = LW'(32'(reg_addr) - A_MSK0);
  assign mc_mask_we  = gated && mask_hit && !sel_q;
  assign vl_mask_we  = gated && mask_hit &&  sel_q;
  assign wr_idx      = idx_q;
  assign win_open    = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      idx_q    <= '0;
      mc_stage <= '0;
      vl_stage <= '0;
      cnt      <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= reg_wdata[0];
        sel_q <= reg_wdata[1];
      end
      if (gated && reg_addr == A_IDX) idx_q <= reg_wdata;
      for (int k = 0; k < MC_BYTES; k++) begin
        if (gated && reg_addr == 4'(A_MC0 + k)) mc_stage[8*k +: 8] <= reg_wdata;
      end
      if (gated && reg_addr == A_VL0) vl_stage[7:0]  <= reg_wdata;
      if (gated && reg_addr == A_VL1) vl_stage[15:8] <= reg_wdata;
      if (commit_fire)  cnt <= CW'(LAT);
      else if (busy)    cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = {5'b0, busy, sel_q, en_q};
    else if (mask_hit) begin
      reg_rdata = sel_q ? vl_mask[8*mask_lane +: 8] : mc_mask[8*mask_lane +: 8];
    end
  end

  AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> (cnt == CW'(LAT)));                          // R4
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt == $past(cnt) - 1'b1));                        // R8
endmodule

// File: rtl/cam_table.sv
module cam_table #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned KW      = 48,
  localparam int unsigned IW     = $clog2(ENTRIES),
  localparam int unsigned MB     = ENTRIES / 8,
  localparam int unsigned LW     = (MB > 1) ? $clog2(MB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_idx,
  input  logic [KW-1:0]      wr_key,
  input  logic               mask_we,
  input  logic [LW-1:0]      mask_lane,
  input  logic [7:0]         mask_byte,
  input  logic [KW-1:0]      key,
  output logic [ENTRIES-1:0] mask,
  output logic [ENTRIES-1:0] hits
);
  logic [KW-1:0] ent [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) ent[e] <= '0;
      mask <= '0;
    end else begin
      if (wr_en) ent[wr_idx[IW-1:0]] <= wr_key;
      if (mask_we) mask[8*mask_lane +: 8] <= mask_byte;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hits[e] = mask[e] && (ent[e] == key);
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_idx) < ENTRIES));                          // R1
endmodule

// File: rtl/rx_addr_cam.sv
module rx_addr_cam
  import rx_cam_pkg::*;
#(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned LAT     = 4,
  localparam int unsigned IW     = $clog2(ENTRIES),
  localparam int unsigned MB     = ENTRIES / 8,
  localparam int unsigned LW     = (MB > 1) ? $clog2(MB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          lk_valid,
  input  logic          lk_vlan,
  input  logic [47:0]   lk_key,
  output logic          lk_done,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx
);
  logic               mc_wr, vl_wr, mc_mask_we, vl_mask_we, win_open;
  logic [7:0]         wr_idx;
  logic [47:0]        mc_stage;
  logic [15:0]        vl_stage;
  logic [LW-1:0]      mask_lane;
  logic [ENTRIES-1:0] mc_mask, vl_mask, mc_hits, vl_hits, sel_hits;
  logic [7:0]         first_idx;

  cam_regs #(.ENTRIES(ENTRIES), .LAT(LAT)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mc_mask, .vl_mask, .mc_wr, .vl_wr, .wr_idx, .mc_stage, .vl_stage,
    .mc_mask_we, .vl_mask_we, .mask_lane, .win_open
  );

  cam_table #(.ENTRIES(ENTRIES), .KW(48)) u_mc (
    .clk, .rst_n, .wr_en(mc_wr), .wr_idx, .wr_key(mc_stage),
    .mask_we(mc_mask_we), .mask_lane, .mask_byte(reg_wdata),
    .key(lk_key), .mask(mc_mask), .hits(mc_hits)
  );

  cam_table #(.ENTRIES(ENTRIES), .KW(16)) u_vl (
    .clk, .rst_n, .wr_en(vl_wr), .wr_idx, .wr_key(vl_stage),
    .mask_we(vl_mask_we), .mask_lane, .mask_byte(reg_wdata),
    .key(lk_key[15:0]), .mask(vl_mask), .hits(vl_hits)
  );

  assign sel_hits  = lk_vlan ? vl_hits : mc_hits;
  assign first_idx = first_one(64'(sel_hits));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_idx  <= '0;
    end else begin
      lk_done <= lk_valid;
      lk_hit  <= lk_valid && (sel_hits != '0);
      lk_idx  <= first_idx[IW-1:0];
    end
  end

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);                                       // R9
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_done && !lk_hit));                        // R9
  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && sel_hits == '0) |=> !lk_hit);                   // R6
  AST_MASK_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_open) |-> ($stable(mc_mask) && $stable(vl_mask))); // R10
endmodule

// File: tb/rx_addr_cam_bench.sv
module rx_addr_cam_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_vlan = 1'b0;
  logic [47:0] lk_key = '0;
  logic        lk_done, lk_hit;
  logic [4:0]  lk_idx;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [47:0] KA = 48'h0100_5E00_0001;
  localparam logic [47:0] KB = 48'h3333_0000_00FB;
  localparam logic [47:0] KC = 48'h0100_5E7F_FFFA;
  localparam logic [47:0] KD = 48'h0100_5E12_3456;
  localparam logic [47:0] KX = 48'h0100_5E0A_0B0C;
  localparam logic [47:0] KY = 48'h0100_5EAA_BBCC;
  localparam logic [47:0] KE = 48'h3333_FF00_1234;

  always #5 clk = ~clk;

  rx_addr_cam u_rx_addr_cam (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .lk_valid, .lk_vlan, .lk_key, .lk_done, .lk_hit, .lk_idx
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // call at a falling edge; returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 20; i++) begin
      rd(4'd0, c);
      if (!c[2]) break;
      @(negedge clk);
    end
  endtask

  task automatic lookup(input logic vl, input logic [47:0] k,
                        output logic done, output logic hit, output logic [4:0] idx);
    lk_valid = 1'b1; lk_vlan = vl; lk_key = k;
    @(posedge clk); #1;
    done = lk_done; hit = lk_hit; idx = lk_idx;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic stage_mc(input logic [7:0] idx, input logic [47:0] k);
    wr(4'd0, 8'h01);
    wr(4'd1, idx);
    for (int b = 0; b < 6; b++) wr(4'(2 + b), k[8*b +: 8]);
  endtask

  task automatic prog_mc(input logic [7:0] idx, input logic [47:0] k);
    stage_mc(idx, k);
    wr(4'd0, 8'h05);
    wait_idle();
  endtask

  task automatic prog_vl(input logic [7:0] idx, input logic [15:0] t);
    wr(4'd0, 8'h03);
    wr(4'd1, idx);
    wr(4'd8, t[7:0]);
    wr(4'd9, t[15:8]);
    wr(4'd0, 8'h07);
    wait_idle();
  endtask

  task automatic set_mask(input logic vl, input logic [31:0] m);
    wr(4'd0, vl ? 8'h03 : 8'h01);
    for (int b = 0; b < 4; b++) wr(4'(10 + b), m[8*b +: 8]);
  endtask

  task automatic t_reset();
    logic [7:0] c; logic d, h; logic [4:0] i;
    rd(4'd0, c);
    check("R7 ctrl after reset", c, 8'h00);
    lookup(1'b0, 48'h0, d, h, i);
    check("R7 mc zero key no hit", h, 0);
    check("R9 done after request", d, 1);
    lookup(1'b1, 48'h0, d, h, i);
    check("R7 vlan zero key no hit", h, 0);
  endtask

  task automatic t_mc_basic();
    logic d, h; logic [4:0] i;
    set_mask(1'b0, (32'd1 << 3) | (32'd1 << 10));
    prog_mc(8'd3, KA);
    lookup(1'b0, KA, d, h, i);
    check("R3 entry 3 hit", {h, i}, {1'b1, 5'd3});
    stage_mc(8'd10, KB);
    lookup(1'b0, KB, d, h, i);
    check("R3 staged only, no hit", h, 0);
    wr(4'd0, 8'h05);
    wait_idle();
    lookup(1'b0, KB, d, h, i);
    check("R3 entry 10 after commit", {h, i}, {1'b1, 5'd10});
    lookup(1'b0, KC, d, h, i);
    check("R9 unknown key miss", {d, h}, 2'b10);
  endtask

  task automatic t_selfclear();
    logic [7:0] c;
    stage_mc(8'd12, KC);
    wr(4'd0, 8'h05);
    for (int k = 0; k < 4; k++) begin
      rd(4'd0, c);
      check("R4 busy during update", c[2], 1);
      @(negedge clk);
    end
    rd(4'd0, c);
    check("R4 self-clear after 4", c[2], 0);
  endtask

  task automatic t_busy_ignore();
    logic d, h; logic [4:0] i;
    set_mask(1'b0, 32'd1 << 8);
    stage_mc(8'd7, KD);
    wr(4'd0, 8'h05);
    wr(4'd1, 8'd8);
    wr(4'd0, 8'h05);
    wait_idle();
    lookup(1'b0, KD, d, h, i);
    check("R8 commit while busy ignored", h, 0);
    set_mask(1'b0, 32'd1 << 7);
    lookup(1'b0, KD, d, h, i);
    check("R8 first commit landed", {h, i}, {1'b1, 5'd7});
  endtask

  task automatic t_range();
    logic d, h; logic [4:0] i;
    set_mask(1'b0, 32'hFFFF_FFFF);
    prog_mc(8'd32, KX);
    prog_mc(8'd40, KX);
    lookup(1'b0, KX, d, h, i);
    check("R1 out-of-range rejected", h, 0);
    prog_mc(8'd31, KX);
    lookup(1'b0, KX, d, h, i);
    check("R1 index 31 accepted", {h, i}, {1'b1, 5'd31});
  endtask

  task automatic t_priority();
    logic d, h; logic [4:0] i;
    set_mask(1'b0, (32'd1 << 5) | (32'd1 << 10));
    prog_mc(8'd5, KB);
    lookup(1'b0, KB, d, h, i);
    check("R9 lowest index wins", {h, i}, {1'b1, 5'd5});
    set_mask(1'b0, 32'd1 << 10);
    lookup(1'b0, KB, d, h, i);
    check("R9 next after mask", {h, i}, {1'b1, 5'd10});
  endtask

  task automatic t_mask();
    logic d, h; logic [4:0] i; logic [7:0] c;
    lookup(1'b0, KA, d, h, i);
    check("R6 disabled entry no match", h, 0);
    rd(4'd11, c);
    check("R6 mask lane 1 readback", c, 8'h04);
  endtask

  task automatic t_vlan();
    logic d, h; logic [4:0] i;
    set_mask(1'b1, 32'd1 << 2);
    prog_vl(8'd2, 16'h0ABC);
    lookup(1'b1, 48'h0000_0000_0ABC, d, h, i);
    check("R5 vlan hit", {h, i}, {1'b1, 5'd2});
    lookup(1'b1, 48'h0000_0000_0ABD, d, h, i);
    check("R5 vlan other tag miss", h, 0);
    lookup(1'b0, 48'h0000_0000_0ABC, d, h, i);
    check("R5 mc table unaffected", h, 0);
    lookup(1'b0, KB, d, h, i);
    check("R6 mc mask kept", {h, i}, {1'b1, 5'd10});
  endtask

  task automatic t_closed();
    logic d, h; logic [4:0] i; logic [7:0] c;
    wr(4'd0, 8'h00);
    wr(4'd10, 8'hFF);
    for (int b = 0; b < 6; b++) wr(4'(2 + b), KY[8*b +: 8]);
    wr(4'd1, 8'd9);
    lookup(1'b0, KA, d, h, i);
    check("R10 mask write discarded", h, 0);
    wr(4'd0, 8'h04);
    rd(4'd0, c);
    check("R2 commit without enable", c, 8'h00);
    wr(4'd0, 8'h01);
    rd(4'd10, c);
    check("R10 mask lane 0 unchanged", c, 8'h00);
    set_mask(1'b0, 32'd1 << 2);
    wr(4'd0, 8'h05);
    wait_idle();
    lookup(1'b0, KY, d, h, i);
    check("R10 data write discarded", h, 0);
    lookup(1'b0, KB, d, h, i);
    check("R10 index write discarded", {h, i}, {1'b1, 5'd2});
  endtask

  task automatic t_same_cycle();
    logic d, h; logic [4:0] i;
    stage_mc(8'd2, KE);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 8'h05;
    lk_valid = 1'b1; lk_vlan = 1'b0; lk_key = KB;
    @(posedge clk); #1;
    check("R9 same-cycle old entry", {lk_hit, lk_idx}, {1'b1, 5'd2});
    @(negedge clk);
    reg_wr = 1'b0; lk_valid = 1'b0;
    wait_idle();
    lookup(1'b0, KB, d, h, i);
    check("R3 old key gone", h, 0);
    lookup(1'b0, KE, d, h, i);
    check("R3 new key present", {h, i}, {1'b1, 5'd2});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mc_basic();
    t_selfclear();
    t_busy_ignore();
    t_range();
    t_priority();
    t_mask();
    t_vlan();
    t_closed();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule